// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one burst access in a synchronous DRAM model or in the datapath of a memory controller. A start strobe loads a starting column and a burst-length code. From the next cycle on, the block presents one column per clock and flags the final beat of the burst. Fixed bursts of 2, 4 or 8 beats wrap inside the naturally aligned block of that size. A full-page burst walks the whole row, wraps from the top column back to zero, and keeps running until a terminate strobe or a new start ends it.

The column width follows the device organisation. The parameter `DQ_WIDTH` takes 16, 8 or 4, and these give a 10, 11 or 12-bit column. A start may arrive on any cycle, including in the middle of a running burst, and the new sequence then takes over at once. The memory array, the data path and command decoding lie outside the block.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While `rst_ni` is low, `valid_o` and `last_o` are 0.
- R2: A start sampled on a rising edge makes `valid_o` 1 and `col_o` equal to the sampled `start_col_i` right after that edge. This is the first beat.
- R3: `blen_i` codes 3'b000, 3'b001, 3'b010 and 3'b011 select bursts of 1, 2, 4 and 8 beats, and `valid_o` stays high for exactly that many consecutive cycles. Code 3'b111 selects full page. Codes 3'b100 to 3'b110 behave as a 1-beat burst.
- R4: In 2, 4 and 8-beat bursts, the column bits below log2(length) increment by one per beat and wrap to zero, while the bits above stay at the starting value. For example, a start at 6 with length 4 gives 6, 7, 4, 5.
- R5: A full-page burst increments the whole `COL_W`-bit column by one per beat. It wraps from 2^COL_W-1 to 0 and continues without an end. `COL_W` is 10, 11 or 12 for `DQ_WIDTH` 16, 8 or 4.
- R6: `last_o` is 1 exactly on the final beat of a fixed-length burst. It is 0 on every beat of a full-page burst.
- R7: A terminate sampled without a start makes `valid_o` 0 after that edge. This applies to full-page bursts too.
- R8: A start sampled while a burst runs replaces that burst at once. A start wins over a terminate sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | COL_W | Starting column of the burst |
| blen_i | input | 3 | Burst-length code |
| term_i | input | 1 | Stop the running burst |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | `col_o` holds a burst beat |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench starts bursts near the top of an aligned block, so a design that carried into the upper column bits would leave the block instead of wrapping inside it. Full-page bursts start two columns below the top of the row; an off-by-one width or a stray last flag shows up at the wrap to column 0. Restarts mid-burst, a start and a terminate on the same edge, and back-to-back single-beat starts catch a design that finishes the old burst or lets the terminate win. A reserved length code checks that it falls back to one beat rather than running on.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } blen_e;

  localparam int unsigned CNT_W = 3;

  function automatic int unsigned col_width(input int unsigned dq);
    case (dq)
      4:       return 12;
      8:       return 11;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/sdr_burst_len_dec.sv
module sdr_burst_len_dec
  import sdr_burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [2:0]       code_i,
  output logic [CNT_W-1:0] beats_m1_o,
  output logic [COL_W-1:0] wrap_mask_o,
  output logic             full_o
);

  always_comb begin
    full_o      = 1'b0;
    beats_m1_o  = '0;
    wrap_mask_o = '0;
    case (code_i)
      BL_2: begin
        beats_m1_o  = CNT_W'(1);
        wrap_mask_o = COL_W'(1);
      end
      BL_4: begin
        beats_m1_o  = CNT_W'(3);
        wrap_mask_o = COL_W'(3);
      end
      BL_8: begin
        beats_m1_o  = CNT_W'(7);
        wrap_mask_o = COL_W'(7);
      end
      BL_PAGE: begin
        full_o      = 1'b1;
        wrap_mask_o = '1;
      end
      default: ; // single beat, reserved codes included
    endcase
  end

endmodule

// File: rtl/sdr_col_step.sv
module sdr_col_step #(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] col_next_o
);

  logic [COL_W-1:0] inc;
  assign inc = col_i + COL_W'(1);

  // masked bits take the incremented value, others hold
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_next_o[b] = mask_i[b] ? inc[b] : col_i[b];
  end

endmodule

// File: rtl/sdr_beat_ctrl.sv
module sdr_beat_ctrl
  import sdr_burst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [CNT_W-1:0] beats_m1_i,
  input  logic             full_i,
  output logic             valid_o,
  output logic             last_o,
  output logic             adv_o,
  output logic             full_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             valid_q, full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      full_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      full_q  <= full_i;
      cnt_q   <= beats_m1_i;
    end else if (term_i) begin
      valid_q <= 1'b0;
    end else if (valid_q && !full_q) begin
      if (cnt_q == '0) valid_q <= 1'b0;
      else             cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign valid_o = valid_q;
  assign full_o  = full_q;
  assign last_o  = valid_q && !full_q && (cnt_q == '0);
  assign adv_o   = valid_q && !start_i && !term_i && !last_o;

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
  import sdr_burst_pkg::*;
#(
  parameter  int unsigned DQ_WIDTH = 16,
  localparam int unsigned COL_W    = col_width(DQ_WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [CNT_W-1:0] beats_m1;
  logic [COL_W-1:0] dec_mask, mask_q, col_q, col_next;
  logic             dec_full, adv, full_q;

  sdr_burst_len_dec #(.COL_W(COL_W)) u_dec (
    .code_i      (blen_i),
    .beats_m1_o  (beats_m1),
    .wrap_mask_o (dec_mask),
    .full_o      (dec_full)
  );

  sdr_beat_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .term_i     (term_i),
    .beats_m1_i (beats_m1),
    .full_i     (dec_full),
    .valid_o    (valid_o),
    .last_o     (last_o),
    .adv_o      (adv),
    .full_o     (full_q)
  );

  sdr_col_step #(.COL_W(COL_W)) u_step (
    .col_i      (col_q),
    .mask_i     (mask_q),
    .col_next_o (col_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      col_q  <= start_col_i;
      mask_q <= dec_mask;
    end else if (adv) begin
      col_q  <= col_next;
    end
  end

  assign col_o = col_q;

endmodule

// File: rtl/sdr_burst_colgen_chk.sv
module sdr_burst_colgen_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic [COL_W-1:0] mask_q,
  input logic             full_q
);

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !last_o));

  assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_burst_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i && !term_i) |=> valid_o);

  assert_wrap_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i && !term_i) |=>
      (((col_o & ~mask_q) == ($past(col_o) & ~$past(mask_q))) &&
       ((col_o & mask_q) == (($past(col_o) + {{(COL_W-1){1'b0}}, 1'b1}) & mask_q))));

  assert_last_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (valid_o && !full_q));

  assert_last_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  assert_term_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !start_i) |=> !valid_o);

endmodule

bind sdr_burst_colgen sdr_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .mask_q      (mask_q),
  .full_q      (full_q)
);

// File: tb/tb_sdr_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdr_burst_colgen;

  localparam int COL_W = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       blen_i = 3'b000;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int errors = 0;
  int checks = 0;

  sdr_burst_colgen #(.DQ_WIDTH(16)) dut (
    .clk_i, .rst_ni, .start_i, .start_col_i, .blen_i, .term_i,
    .col_o, .valid_o, .last_o
  );

  always #2 clk_i = ~clk_i;

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive inputs for one edge, then sample just after it
  task automatic cyc(logic s, int c, logic [2:0] b, logic t);
    start_i = s; start_col_i = COL_W'(c); blen_i = b; term_i = t;
    @(posedge clk_i); #1;
    start_i = 1'b0; term_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", "valid in reset", int'(valid_o), 0);
    chk("R1", "last in reset", int'(last_o), 0);
    rst_ni = 1'b1;
    cyc(0, 0, 3'b000, 0);
    chk("R1", "valid after reset", int'(valid_o), 0);
  endtask

  task automatic t_fixed(string req, int col, logic [2:0] code, int n);
    cyc(1, col, code, 0);
    for (int i = 0; i < n; i++) begin
      int base = (n > 1) ? (col & ~(n - 1)) : col;
      int exp  = (n > 1) ? (base | ((col + i) & (n - 1))) : col;
      chk(req, "valid", int'(valid_o), 1);
      chk(req, "col", int'(col_o), exp);
      chk("R6", "last on fixed", int'(last_o), (i == n - 1) ? 1 : 0);
      if (i < n - 1) cyc(0, 0, 3'b000, 0);
    end
    cyc(0, 0, 3'b000, 0);
    chk("R3", "valid after burst", int'(valid_o), 0);
  endtask

  task automatic t_full_wrap();
    cyc(1, 1022, 3'b111, 0);
    for (int i = 0; i < 6; i++) begin
      chk("R5", "full-page col", int'(col_o), (1022 + i) % 1024);
      chk("R5", "full-page valid", int'(valid_o), 1);
      chk("R6", "no last in page", int'(last_o), 0);
      cyc(0, 0, 3'b000, (i == 5) ? 1'b1 : 1'b0);
    end
    chk("R7", "terminate full page", int'(valid_o), 0);
  endtask

  task automatic t_term_fixed();
    cyc(1, 32, 3'b011, 0);
    cyc(0, 0, 3'b000, 0);
    chk("R4", "second beat", int'(col_o), 33);
    cyc(0, 0, 3'b000, 1);
    chk("R7", "terminate fixed", int'(valid_o), 0);
    chk("R7", "no last after term", int'(last_o), 0);
  endtask

  task automatic t_restart();
    cyc(1, 16, 3'b011, 0);
    cyc(0, 0, 3'b000, 0);
    chk("R8", "old burst beat", int'(col_o), 17);
    cyc(1, 53, 3'b010, 0);
    chk("R8", "restart col", int'(col_o), 53);
    cyc(0, 0, 3'b000, 0);
    chk("R8", "restart wrap 1", int'(col_o), 54);
    cyc(0, 0, 3'b000, 0);
    chk("R8", "restart wrap 2", int'(col_o), 55);
    cyc(0, 0, 3'b000, 0);
    chk("R8", "restart wrap 3", int'(col_o), 52);
    chk("R8", "restart last", int'(last_o), 1);
    cyc(0, 0, 3'b000, 0);
    chk("R8", "restart ends", int'(valid_o), 0);
  endtask

  task automatic t_start_beats_term();
    cyc(1, 100, 3'b111, 0);
    cyc(1, 200, 3'b001, 1);
    chk("R8", "start over term valid", int'(valid_o), 1);
    chk("R8", "start over term col", int'(col_o), 200);
    cyc(0, 0, 3'b000, 0);
    chk("R8", "start over term 2nd", int'(col_o), 201);
    chk("R8", "start over term last", int'(last_o), 1);
    cyc(0, 0, 3'b000, 0);
    chk("R8", "start over term end", int'(valid_o), 0);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 4; i++) begin
      cyc(1, 300 + 7 * i, 3'b000, 0);
      chk("R2", "single col", int'(col_o), 300 + 7 * i);
      chk("R2", "single valid", int'(valid_o), 1);
      chk("R6", "single last", int'(last_o), 1);
    end
    cyc(0, 0, 3'b000, 0);
    chk("R3", "singles end", int'(valid_o), 0);
  endtask

  initial begin
    t_reset();
    t_fixed("R3", 77, 3'b000, 1);
    t_fixed("R4", 5, 3'b001, 2);
    t_fixed("R4", 6, 3'b010, 4);
    t_fixed("R4", 13, 3'b011, 8);
    t_fixed("R4", 1021, 3'b011, 8);
    t_fixed("R3", 40, 3'b101, 1);
    t_full_wrap();
    t_term_fixed();
    t_restart();
    t_start_beats_term();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule